// File: doc/BRIEF.md
# Dual-Clock Ping-Pong Row Buffer

This block holds video rows on their way from a source pixel clock to a display-link byte clock, where the two clocks are unrelated. Each half of the screen gets its own instance. The source side delivers a 96-bit word per cycle, which is four 24-bit pixels, along with its own vertical sync, horizontal sync and active strobes. The link side has its own three strobes and pulls the row back out at its own pace.

There are two row memories. Source rows go into them in alternation. While the source fills one memory, the link reads the row that was completed just before it into the other. Reading therefore trails writing by exactly one row, and the block needs no occupancy flags. Only two single-bit facts cross between the clock domains: which memory is currently being written, and whether any row has been finished since the last source frame start. If the link side starts a row when no such row exists, it sends zero pixels.

Top module: `lane_row_pingpong`

## Requirements
- R1: While either reset is held and after both are released, `r_data` is all zeros until a read row has been started on a completed source row.
- R2: A read row that starts (on `r_hsync`) before any source row has been completed since the last `w_vsync` delivers all-zero words.
- R3: When a read row starts on a completed source row, each cycle with `r_active` high returns the next word of that row. The first word is word 0, and each word appears on `r_data` one `rclk` cycle after the cycle that requested it.
- R4: Source rows alternate between the two memories, with a row parity bit choosing the memory. Writing a new source row while the previous row is being read does not disturb the words being read. The memory chosen for reading only changes on `r_hsync` or `r_vsync`.
- R5: `w_hsync` returns the write column to word 0 and closes a row only if at least one word was written in it. A short row reads back correctly from word 0.
- R6: Words beyond `WORDS` per row are dropped on the write side. They never overwrite the earlier words of the row.
- R7: After `r_vsync`, `r_data` stays zero until the next `r_hsync`, even while `r_active` is high.
- R8: `w_vsync` clears the record of completed rows. A read row started after this reaches the link side delivers zeros.
- R9: In any cycle that follows an `rclk` cycle with `r_active` low, `r_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Source pixel clock |
| wrst_n | input | 1 | Synchronous active-low reset, source domain |
| w_vsync | input | 1 | Source frame start strobe |
| w_hsync | input | 1 | Source row boundary strobe |
| w_active | input | 1 | Source word valid |
| w_data | input | 96 | Four 24-bit pixels |
| rclk | input | 1 | Link byte clock |
| rrst_n | input | 1 | Synchronous active-low reset, link domain |
| r_vsync | input | 1 | Link frame start strobe |
| r_hsync | input | 1 | Link row start strobe |
| r_active | input | 1 | Link word request |
| r_data | output | 96 | Four 24-bit pixels, one cycle after request |

## Verification
The assertions assume several things about the inputs. A sync strobe and a data strobe in the same cycle resolve in favour of the sync. A link row starts only after the last source row boundary has had several `rclk` cycles to cross the synchroniser. Read rows request at most `WORDS` words. The stimulus meets these rules: it pulses each sync for one cycle with data idle, and it waits eight link cycles after every source row boundary before issuing `r_hsync`. The only exception is the overlap test, which deliberately writes the next row while the previous one is being read.

// File: rtl/rpb_pkg.sv
// Shared types for the ping-pong row buffer.
// Assumes: nothing beyond the standard types.
package rpb_pkg;
    // Write-side state that is handed to the read clock domain.
    typedef struct packed {
        logic parity;   // memory currently being filled
        logic any_done; // a row has closed since the last frame start
    } wr_state_t;
endpackage

// File: rtl/rpb_sync.sv
// Multi-flop synchroniser for a single level signal.
// Assumes: the input stays put for longer than STAGES destination cycles.
module rpb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rpb_bank.sv
// One row memory: a write port on the source clock and a registered read port on the link clock.
// Assumes: the addresses are below WORDS whenever the port enables are high.
module rpb_bank #(
    parameter int WORDS = 225,
    parameter int DW    = 96,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] q
);
    logic [DW-1:0] mem [WORDS];

    // Store one word from the source side.
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Fetch one word for the link side.
    always_ff @(posedge rclk) begin
        if (re) q <= mem[raddr];
    end
endmodule

// File: rtl/rpb_write_ctrl.sv
// Source-side row control: column counter, row parity and the row-completed flag.
// Assumes: syncs take priority over w_active; writes past WORDS words are dropped.
module rpb_write_ctrl
    import rpb_pkg::*;
#(
    parameter int WORDS = 225,
    localparam int AW   = $clog2(WORDS),
    localparam int CW   = $clog2(WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vsync,
    input  logic          hsync,
    input  logic          active,
    output logic [1:0]    we_bank,
    output logic [AW-1:0] waddr,
    output wr_state_t     state
);
    logic [CW-1:0] col;
    logic          parity;
    logic          any_done;
    logic          wr_ok;

    // A write happens only inside the row and on a cycle with no sync.
    assign wr_ok = active && !vsync && !hsync && (col < CW'(WORDS));

    // Advance the column; close the row on hsync; clear everything on vsync.
    always_ff @(posedge clk) begin
        if (!rst_n || vsync) begin
            col      <= '0;
            parity   <= 1'b0;
            any_done <= 1'b0;
        end else if (hsync) begin
            col <= '0;
            if (col != '0) begin
                parity   <= ~parity;
                any_done <= 1'b1;
            end
        end else if (wr_ok) begin
            col <= col + 1'b1;
        end
    end

    // Route the write to the memory chosen by the row parity.
    always_comb begin
        we_bank         = 2'b00;
        we_bank[parity] = wr_ok;
    end

    assign waddr          = col[AW-1:0];
    assign state.parity   = parity;
    assign state.any_done = any_done;

    AST_WCOL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        col <= CW'(WORDS)) else $error("write column past row end"); // R6
    AST_HSYNC_COL: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |=> (col == '0)) else $error("hsync did not rewind column"); // R5
    AST_VSYNC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> !any_done) else $error("vsync did not clear row flag"); // R8
endmodule

// File: rtl/rpb_read_ctrl.sv
// Link-side row control: picks the memory at row start and walks the read column.
// Assumes: parity_s and done_s are already synchronised to clk.
module rpb_read_ctrl #(
    parameter int WORDS = 225,
    localparam int AW   = $clog2(WORDS),
    localparam int CW   = $clog2(WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vsync,
    input  logic          hsync,
    input  logic          active,
    input  logic          parity_s,
    input  logic          done_s,
    output logic          rd_en,
    output logic [AW-1:0] raddr,
    output logic          sel,
    output logic          row_ok
);
    logic [CW-1:0] col;

    // A read happens only inside the row and on a cycle with no sync.
    assign rd_en = active && !vsync && !hsync && (col < CW'(WORDS));

    // Latch the finished memory on hsync and forget it on vsync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col    <= '0;
            sel    <= 1'b0;
            row_ok <= 1'b0;
        end else if (vsync) begin
            col    <= '0;
            row_ok <= 1'b0;
        end else if (hsync) begin
            col    <= '0;
            sel    <= ~parity_s;
            row_ok <= done_s;
        end else if (rd_en) begin
            col <= col + 1'b1;
        end
    end

    assign raddr = col[AW-1:0];

    AST_RSEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hsync && !vsync) |=> $stable(sel)) else $error("read memory changed mid row"); // R4
endmodule

// File: rtl/lane_row_pingpong.sv
// Ping-pong row buffer between a source clock and a link clock, one per screen half.
// Assumes: the link starts each row at least STAGES+1 rclk cycles after the source row closed.
module lane_row_pingpong
    import rpb_pkg::*;
#(
    parameter int WORDS     = 225,
    parameter int PIX_W     = 24,
    parameter int PIX_WORD  = 4,
    parameter int STAGES    = 2,
    localparam int DW       = PIX_W * PIX_WORD,
    localparam int AW       = $clog2(WORDS)
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          w_vsync,
    input  logic          w_hsync,
    input  logic          w_active,
    input  logic [DW-1:0] w_data,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          r_vsync,
    input  logic          r_hsync,
    input  logic          r_active,
    output logic [DW-1:0] r_data
);
    logic [1:0]    we_bank;
    logic [AW-1:0] waddr;
    wr_state_t     wst;
    logic          parity_s, done_s;
    logic          rd_en, sel, row_ok;
    logic [AW-1:0] raddr;
    logic [DW-1:0] q [2];
    logic          out_q, sel_q;

    rpb_write_ctrl #(.WORDS(WORDS)) wctl_i (
        .clk(wclk), .rst_n(wrst_n), .vsync(w_vsync), .hsync(w_hsync),
        .active(w_active), .we_bank(we_bank), .waddr(waddr), .state(wst));

    // The done flag gets one extra stage so the parity bit settles first.
    rpb_sync #(.STAGES(STAGES))     sync_par_i  (.clk(rclk), .rst_n(rrst_n), .d(wst.parity),   .q(parity_s));
    rpb_sync #(.STAGES(STAGES + 1)) sync_done_i (.clk(rclk), .rst_n(rrst_n), .d(wst.any_done), .q(done_s));

    rpb_read_ctrl #(.WORDS(WORDS)) rctl_i (
        .clk(rclk), .rst_n(rrst_n), .vsync(r_vsync), .hsync(r_hsync),
        .active(r_active), .parity_s(parity_s), .done_s(done_s),
        .rd_en(rd_en), .raddr(raddr), .sel(sel), .row_ok(row_ok));

    for (genvar b = 0; b < 2; b++) begin : g_bank
        rpb_bank #(.WORDS(WORDS), .DW(DW)) bank_i (
            .wclk(wclk), .we(we_bank[b]), .waddr(waddr), .wdata(w_data),
            .rclk(rclk), .re(rd_en && (sel == b[0])), .raddr(raddr), .q(q[b]));
    end

    // Track which fetches carry valid data and from which memory.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            out_q <= 1'b0;
            sel_q <= 1'b0;
        end else begin
            out_q <= rd_en && row_ok;
            sel_q <= sel;
        end
    end

    assign r_data = out_q ? q[sel_q] : '0;

    AST_IDLE_ZERO: assert property (@(posedge rclk) disable iff (!rrst_n)
        !r_active |=> (r_data == '0)) else $error("data without request"); // R9
    AST_RVSYNC_ZERO: assert property (@(posedge rclk) disable iff (!rrst_n)
        r_vsync |=> (r_data == '0)) else $error("data after link vsync"); // R7
endmodule

// File: tb/lane_row_pingpong_tb_top.sv
module lane_row_pingpong_tb_top;
    localparam int WORDS = 6;
    localparam int DW    = 96;

    logic wclk = 0, rclk = 0;
    logic wrst_n = 0, rrst_n = 0;
    logic w_vsync = 0, w_hsync = 0, w_active = 0;
    logic [DW-1:0] w_data = '0;
    logic r_vsync = 0, r_hsync = 0, r_active = 0;
    logic [DW-1:0] r_data;
    int checks = 0, fails = 0;
    bit finished = 0;

    always #2.5 wclk = ~wclk;   // 200 MHz source clock
    always #3.5 rclk = ~rclk;   // unrelated link clock

    lane_row_pingpong #(.WORDS(WORDS)) dut_i (.*);

    // Stimulus table: words written per row, words to compare.
    typedef struct packed { logic [7:0] n_wr; logic [7:0] n_chk; } vec_t;
    localparam vec_t VECS [4] = '{
        '{8'd6, 8'd6},   // full row (R3)
        '{8'd3, 8'd3},   // short row (R5)
        '{8'd8, 8'd6},   // overfull row, extra words dropped (R6)
        '{8'd1, 8'd1}    // single word (R5)
    };

    function automatic logic [DW-1:0] word(int tag, int c);
        return {8'(tag), 8'(c), {10{8'(tag ^ c ^ 8'h5a)}}};
    endfunction

    task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wpulse_v();
        @(negedge wclk) w_vsync = 1;
        @(negedge wclk) w_vsync = 0;
    endtask

    task automatic write_row(int tag, int n);
        for (int c = 0; c < n; c++) begin
            @(negedge wclk) w_active = 1; w_data = word(tag, c);
        end
        @(negedge wclk) w_active = 0;
        @(negedge wclk) w_hsync = 1;
        @(negedge wclk) w_hsync = 0;
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
    endtask

    // Optionally start a link row, request WORDS words, compare the first n_chk.
    task automatic read_row(bit start, bit ok, int tag, int n_chk, string req);
        if (start) begin
            @(negedge rclk) r_hsync = 1;
            @(negedge rclk) r_hsync = 0;
        end
        for (int c = 0; c <= WORDS; c++) begin
            @(negedge rclk);
            if (c > 0 && c - 1 < n_chk) begin
                logic [DW-1:0] e;
                e = ok ? word(tag, c - 1) : '0;
                chk(r_data === e, req, r_data, e);
            end
            r_active = (c < WORDS);
        end
        @(negedge rclk);
        chk(r_data === '0, "R9 idle after row", r_data, '0);
    endtask

    initial begin
        repeat (4) @(negedge rclk);
        chk(r_data === '0, "R1 in reset", r_data, '0);
        wrst_n = 1; rrst_n = 1;
        @(negedge rclk);
        chk(r_data === '0, "R1 after reset", r_data, '0);
        read_row(1, 0, 0, WORDS, "R1/R2 no row yet");
        wpulse_v();
        settle();
        read_row(1, 0, 0, WORDS, "R2 empty frame");

        // Table walk: write a row, wait for crossing, read it back.
        for (int i = 0; i < 4; i++) begin
            write_row(i + 1, int'(VECS[i].n_wr));
            settle();
            read_row(1, 1, i + 1, int'(VECS[i].n_chk), "R3/R5/R6 table row");
        end

        // R4: write the next row while the previous one is read.
        write_row(20, WORDS);
        settle();
        fork
            read_row(1, 1, 20, WORDS, "R4 read during write");
            write_row(21, WORDS);
        join
        settle();
        read_row(1, 1, 21, WORDS, "R4 next row");

        // R7: link vsync then requests without hsync give zeros.
        @(negedge rclk) r_vsync = 1;
        @(negedge rclk) r_vsync = 0;
        read_row(0, 0, 0, WORDS, "R7 after link vsync");
        read_row(1, 1, 21, WORDS, "R7 row restarts");

        // R8: source vsync forgets completed rows.
        wpulse_v();
        settle();
        read_row(1, 0, 0, WORDS, "R8 after source vsync");

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge wclk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule